// File: doc/BRIEF.md
# Single-Step Custom-Order Three-Bit Counter

This block is a three-bit synchronous counter whose outputs walk a fixed loop of eight codes in which exactly one bit flips per step. The order is not the reflected binary Gray order. From 000 it goes to 001, 101, 100, 110, 111, 011 and 010, and then back to 000. Because only one output bit moves on any advance, a consumer in another clock domain, or a decoder that has glitch-sensitive loads, never sees a false intermediate code.

The counter advances on a rising clock edge while the count enable is high. It holds its value while the enable is low. A synchronous clear forces the code 000 and overrides the enable. An active-low synchronous reset does the same at power-up. An optional flag marks the last code of the loop, 010, so that a neighbour can tell that the next enabled step will wrap. The state is held in plain D flip-flops. Next-state logic computes the successor, and a parameter selects either reduced gate equations or a successor lookup.

Top module: `gray_seq_counter`

## Requirements
- R1: While rst_n is low at a rising clock edge, the code {q3,q2,q1} becomes 000 after that edge, whatever clr and cnt_en are.
- R2: With rst_n high and clr high at a rising edge, the code becomes 000 after that edge.
- R3: With rst_n high, clr low and cnt_en high, the code advances one place in the loop 000→001→101→100→110→111→011→010, written as {q3,q2,q1} with q3 the most significant bit.
- R4: With rst_n high, clr low and cnt_en low, the code does not change.
- R5: An enabled advance from 010 gives 000, so the loop closes.
- R6: Every enabled advance without clear changes exactly one of q3, q2 and q1.
- R7: With the flag option on (HAS_WRAP_FLAG=1, the default), wrap_flag is high exactly while the code is 010, so an enabled advance taken while it is high lands on 000.
- R8: Clear takes priority over count enable: clr and cnt_en both high gives 000, not the successor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset to code 000 |
| clr | input | 1 | Synchronous clear to code 000, overrides cnt_en |
| cnt_en | input | 1 | Advance one place in the loop on this edge |
| q3 | output | 1 | Code bit, most significant |
| q2 | output | 1 | Code bit, middle |
| q1 | output | 1 | Code bit, least significant |
| wrap_flag | output | 1 | High while the code is 010, the last code before the wrap |

## Verification
The main counting function is driven with unbroken runs of enable that cover all eight codes. This shows whether each successor matches the custom order and whether any step flips more than one bit. Enable gaps in the middle of a run separate a correct hold from a stray advance. A clear asserted together with enable, and also alone, separates clear priority from ordinary counting. A run that goes past 010 shows whether the loop closes to 000 and whether the wrap flag follows the code 010. A final sweep clears from each of the eight codes, to show that no state ignores clear.

// File: rtl/gray_seq_pkg.sv
// Package: shared widths, code type and the fixed loop endpoints for the
// custom-order counter. Assumes a three-bit code; the loop order is fixed.
package gray_seq_pkg;
    localparam int CODE_W = 3;
    typedef logic [CODE_W-1:0] code_t;
    localparam code_t CODE_FIRST = 3'b000;
    localparam code_t CODE_LAST  = 3'b010;
endpackage

// File: rtl/gray_seq_next.sv
// Module: successor logic. Maps the present code onto the next one in the
// loop 000,001,101,100,110,111,011,010. USE_TABLE picks a lookup (1) or the
// reduced two-level gate equations (0). Purely combinational.
module gray_seq_next
    import gray_seq_pkg::*;
#(
    parameter bit USE_TABLE = 1'b0
) (
    input  code_t cur,
    output code_t nxt
);
    generate
        if (USE_TABLE) begin : g_table
            // Successor lookup, one entry per code.
            always_comb begin
                case (cur)
                    3'b000:  nxt = 3'b001;
                    3'b001:  nxt = 3'b101;
                    3'b101:  nxt = 3'b100;
                    3'b100:  nxt = 3'b110;
                    3'b110:  nxt = 3'b111;
                    3'b111:  nxt = 3'b011;
                    3'b011:  nxt = 3'b010;
                    default: nxt = 3'b000;
                endcase
            end
        end else begin : g_gates
            logic b3, b2, b1;
            assign b3 = cur[2];
            assign b2 = cur[1];
            assign b1 = cur[0];
            // Reduced equations taken from the three-variable maps.
            always_comb begin
                nxt[0] = ~(b3 ^ b2);
                nxt[1] = b1 ? b2 : b3;
                nxt[2] = (b3 & ~(b2 & b1)) | (~b3 & ~b2 & b1);
            end
        end
    endgenerate
endmodule

// File: rtl/gray_seq_state.sv
// Module: D flip-flop bank holding the code. Reset (active low) and clear are
// both synchronous; clear outranks enable. Assumes one clock domain.
module gray_seq_state #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] d_next,
    output logic [W-1:0] q
);
    // State update: reset, then clear, then enabled advance, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (en)
            q <= d_next;
    end
endmodule

// File: rtl/gray_seq_wrap.sv
// Module: last-code detector. With ENABLE set it raises the flag while the
// code equals LAST; otherwise the flag is tied low. Combinational.
module gray_seq_wrap
    import gray_seq_pkg::*;
#(
    parameter bit    ENABLE = 1'b1,
    parameter code_t LAST   = CODE_LAST
) (
    input  code_t cur,
    output logic  flag
);
    generate
        if (ENABLE) begin : g_on
            // Compare against the loop's final code.
            assign flag = (cur == LAST);
        end else begin : g_off
            logic unused_ok;
            assign unused_ok = ^cur;
            assign flag      = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/gray_seq_counter.sv
// Module: top of the custom-order single-step counter. Joins the successor
// logic, the state bank and the optional last-code flag. Assumes inputs are
// synchronous to clk.
module gray_seq_counter
    import gray_seq_pkg::*;
#(
    parameter bit USE_TABLE     = 1'b0,
    parameter bit HAS_WRAP_FLAG = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cnt_en,
    output logic q3,
    output logic q2,
    output logic q1,
    output logic wrap_flag
);
    code_t code_q;
    code_t code_d;

    gray_seq_next #(.USE_TABLE(USE_TABLE)) u_next (
        .cur (code_q),
        .nxt (code_d)
    );

    gray_seq_state #(.W(CODE_W)) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .en     (cnt_en),
        .d_next (code_d),
        .q      (code_q)
    );

    gray_seq_wrap #(.ENABLE(HAS_WRAP_FLAG), .LAST(CODE_LAST)) u_wrap (
        .cur  (code_q),
        .flag (wrap_flag)
    );

    // Split the code onto the named output bits.
    assign q3 = code_q[2];
    assign q2 = code_q[1];
    assign q1 = code_q[0];
endmodule

// File: rtl/gray_seq_counter_chk.sv
// Module: property checker for gray_seq_counter, attached by bind. Sees only
// the top-level ports. Assumes the default flag option for the R7 check.
module gray_seq_counter_chk (
    input logic clk,
    input logic rst_n,
    input logic clr,
    input logic cnt_en,
    input logic q3,
    input logic q2,
    input logic q1,
    input logic wrap_flag
);
    logic [2:0] code;
    logic       rst_was_low;
    assign code = {q3, q2, q1};

    // Remember whether reset was applied on the previous edge.
    always_ff @(posedge clk) rst_was_low <= !rst_n;

    // R1
    always @(posedge clk) begin
        if (rst_was_low === 1'b1)
            reset_zero_chk: assert (code == 3'b000);
    end

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (code == 3'b000));

    // R3
    first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_en && code == 3'b000) |=> (code == 3'b001));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !cnt_en) |=> $stable(code));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_en && code == 3'b010) |=> (code == 3'b000));

    // R6
    one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_en) |=> ($countones(code ^ $past(code)) == 1));

    // R7
    flag_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_flag && cnt_en && !clr) |=> (code == 3'b000));

    // R8
    clear_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && cnt_en) |=> !wrap_flag && (code == 3'b000));
endmodule

bind gray_seq_counter gray_seq_counter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .cnt_en    (cnt_en),
    .q3        (q3),
    .q2        (q2),
    .q1        (q1),
    .wrap_flag (wrap_flag)
);

// File: tb/gray_seq_counter_bench.sv
module gray_seq_counter_bench;
    logic clk = 1'b0;
    logic rst_n, clr, cnt_en;
    logic q3, q2, q1, wrap_flag;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #4 clk = ~clk;

    gray_seq_counter u_gray_seq_counter (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_en(cnt_en),
        .q3(q3), .q2(q2), .q1(q1), .wrap_flag(wrap_flag)
    );

    // Vector: {clr, cnt_en, expected code after the edge}
    localparam int NV = 20;
    localparam logic [4:0] VEC [NV] = '{
        {2'b01, 3'b001}, {2'b01, 3'b101}, {2'b00, 3'b101}, {2'b01, 3'b100},
        {2'b01, 3'b110}, {2'b11, 3'b000}, {2'b01, 3'b001}, {2'b01, 3'b101},
        {2'b01, 3'b100}, {2'b01, 3'b110}, {2'b00, 3'b110}, {2'b01, 3'b111},
        {2'b01, 3'b011}, {2'b01, 3'b010}, {2'b00, 3'b010}, {2'b01, 3'b000},
        {2'b01, 3'b001}, {2'b00, 3'b001}, {2'b10, 3'b000}, {2'b00, 3'b000}
    };

    // Successor in the custom loop, written from R3 and R5.
    function automatic logic [2:0] succ(input logic [2:0] c);
        case (c)
            3'b000: succ = 3'b001;  3'b001: succ = 3'b101;
            3'b101: succ = 3'b100;  3'b100: succ = 3'b110;
            3'b110: succ = 3'b111;  3'b111: succ = 3'b011;
            3'b011: succ = 3'b010;  default: succ = 3'b000;
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic e);
        clr = c; cnt_en = e;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [2:0] prev, cur;
        rst_n = 1'b0; clr = 1'b0; cnt_en = 1'b1;
        @(negedge clk); @(negedge clk);
        // R1: reset state
        check("R1", {q3, q2, q1}, 3'b000);
        check("R7", {2'b00, wrap_flag}, 3'b000);
        rst_n = 1'b1;
        prev = 3'b000;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic vc, ve;
            logic [2:0] ve_code;
            string tag;
            {vc, ve, ve_code} = VEC[i];
            step(vc, ve);
            cur = {q3, q2, q1};
            if (vc && ve) tag = "R8";
            else if (vc) tag = "R2";
            else if (!ve) tag = "R4";
            else if (prev == 3'b010) tag = "R5";
            else tag = "R3";
            check(tag, cur, ve_code);
            if (!vc && ve) begin
                check("R3 successor", cur, succ(prev));
                check("R6 one bit", 3'($countones(cur ^ prev)), 3'd1);
            end
            check("R7 flag", {2'b00, wrap_flag}, {2'b00, (ve_code == 3'b010)});
            prev = cur;
        end

        // Full loop of nine enabled steps from 000: R3, R5, R6, R7.
        for (int k = 0; k < 9; k++) begin
            step(1'b0, 1'b1);
            cur = {q3, q2, q1};
            check("R3 loop", cur, succ(prev));
            check("R6 loop", 3'($countones(cur ^ prev)), 3'd1);
            check("R7 loop", {2'b00, wrap_flag}, {2'b00, (cur == 3'b010)});
            prev = cur;
        end

        // Clear from every code: R2.
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 1'b0);
            for (int j = 0; j < k; j++) step(1'b0, 1'b1);
            step(1'b1, 1'b0);
            check("R2 sweep", {q3, q2, q1}, 3'b000);
        end

        // Reset mid-count with enable and clear low: R1.
        step(1'b0, 1'b1); step(1'b0, 1'b1);
        rst_n = 1'b0;
        step(1'b0, 1'b1);
        check("R1 midrun", {q3, q2, q1}, 3'b000);
        rst_n = 1'b1;
        step(1'b0, 1'b0);
        check("R4 after reset", {q3, q2, q1}, 3'b000);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule